// File: doc/BRIEF.md
# Packed Register-Write Command Decoder

The decoder sits between a command-fetch engine and a register bus. It takes a stream of 32-bit command words and turns every group of five words into up to four register writes. The first word of a group packs four 8-bit register indices, and the four words after it are the values for those indices, slot for slot. Each index is expanded into a full byte address in one of two 512-byte register windows, and the writes are then issued in slot order on a valid/ready write bus.

A reserved padding index fills unused slots and produces no bus traffic. The upper half of the first window is the execute region. A write that lands there is what starts the accumulated drawing operation, and the decoder flags it with a one-cycle batch pulse. A group is issued only once all five words have arrived. A group that the end-of-stream marker cuts short is thrown away and sets a sticky error flag.

Top module: `regwr_unpacker`

## Requirements
- R1: A group is exactly five words: one index word, then four value words. `in_last_i` is allowed on the fifth word. The first write of a group appears on the bus in the cycle after its fifth word is accepted.
- R2: Slot k (k = 0..3) takes its index from index-word bits [8k+7:8k] and its data from the (k+1)-th value word. Non-padding slots are written in ascending slot order.
- R3: An index with bit 7 clear maps to byte address 0x1C00 + 4 × index[6:0], which lies in the range 0x1C00..0x1DFF.
- R4: An index with bit 7 set maps to byte address 0x2C00 + 4 × index[6:0], which lies in the range 0x2C00..0x2DFF.
- R5: Index 0x15 (address 0x1C54) is padding. It produces no bus write and costs no bus cycle. A group made only of padding produces no writes, and `in_ready_o` stays high.
- R6: `in_ready_o` is low from the cycle after the fifth word is accepted until the cycle after the last write of that group is accepted. A write that is stalled keeps its address and data stable.
- R7: `batch_done_o` is high for exactly the cycle after the bus accepts a write to 0x1D00..0x1DFF (window 0, index 0x40..0x7F). Writes to window 1 never raise it.
- R8: If `in_last_i` arrives with any of the first four words of a group, `err_o` is set and stays set until reset. No write of that group is issued, and the next accepted word is treated as an index word.
- R9: While `rst_ni` is low and after its release, `in_ready_o` is 1 and `wr_valid_o`, `batch_done_o` and `err_o` are 0. A partial group is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Command word valid |
| in_ready_o | output | 1 | Decoder accepts a command word |
| in_data_i | input | 32 | Command word |
| in_last_i | input | 1 | Word is the last of the stream |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Register bus accepts the write |
| wr_addr_o | output | 16 | Byte address of the write |
| wr_data_o | output | 32 | Write data |
| batch_done_o | output | 1 | One-cycle pulse after an execute-region write |
| err_o | output | 1 | Sticky truncated-group flag |

## Verification
The hardest situation to reach is an end-of-stream marker arriving mid-group, combined with a reset part-way through a group. In both cases the decoder must throw away words it already holds and then resynchronise on the next index word. The stimulus creates each case deliberately: it stops a group after two or three words, with the marker or with a reset pulse, and then sends a full group whose index word would be misread as data if any stale count survived. Random index words and a random ready pattern on the write bus cover stalls in every slot, window-boundary indices and mixed padding. Meanwhile a queue-based model predicts every output on every cycle.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  localparam int unsigned SLOTS = 4;
  localparam int unsigned WORDS = SLOTS + 1;
  localparam int unsigned SEL_W = $clog2(SLOTS);
  localparam int unsigned CNT_W = $clog2(WORDS);
endpackage

// File: rtl/regwr_addr_map.sv
module regwr_addr_map #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 8,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00,
  parameter logic [ADDR_W-1:0] EXEC_OFS  = 16'h0100,
  parameter logic [IDX_W-1:0]  PAD_IDX   = 8'h15
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pad_o,
  output logic              exec_o
);
  logic [ADDR_W-1:0] offs;
  logic              win1;

  assign win1   = idx_i[IDX_W-1];
  assign offs   = ADDR_W'({idx_i[IDX_W-2:0], 2'b00});
  assign addr_o = (win1 ? WIN1_BASE : WIN0_BASE) + offs;
  assign pad_o  = (idx_i == PAD_IDX);
  // execute region: upper half of window 0 only
  assign exec_o = !win1 && (|(offs & EXEC_OFS));
endmodule

// File: rtl/regwr_collect.sv
module regwr_collect
  import regwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  input  logic [DATA_W-1:0]            in_data_i,
  input  logic                         in_last_i,
  input  logic                         busy_i,
  output logic                         in_ready_o,
  output logic                         grp_load_o,
  output logic [DATA_W-1:0]            idx_word_o,
  output logic [SLOTS-1:0][DATA_W-1:0] val_o,
  output logic                         err_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             trunc;

  assign in_ready_o = !busy_i;
  assign accept     = in_valid_i && in_ready_o;
  assign trunc      = accept && in_last_i && (cnt_q != LAST_CNT);
  assign grp_load_o = accept && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (accept) begin
      if (trunc || cnt_q == LAST_CNT) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      idx_word_o <= '0;
    else if (accept && cnt_q == '0)   idx_word_o <= in_data_i;
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_val
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   val_o[k] <= '0;
      else if (accept && cnt_q == CNT_W'(k + 1))     val_o[k] <= in_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (trunc) err_o <= 1'b1;
  end
endmodule

// File: rtl/regwr_issue.sv
module regwr_issue
  import regwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         grp_load_i,
  input  logic [SLOTS-1:0]             keep_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [SLOTS-1:0]             exec_i,
  input  logic [SLOTS-1:0][DATA_W-1:0] data_i,
  input  logic                         wr_ready_i,
  output logic                         wr_valid_o,
  output logic [ADDR_W-1:0]            wr_addr_o,
  output logic [DATA_W-1:0]            wr_data_o,
  output logic                         busy_o,
  output logic                         batch_done_o
);
  logic [SLOTS-1:0] pend_q;
  logic [SEL_W-1:0] sel;
  logic             found;
  logic             fire;

  // lowest pending slot first; padding slots never enter pend_q
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (pend_q[k] && !found) begin
        sel   = SEL_W'(k);
        found = 1'b1;
      end
    end
  end

  assign wr_valid_o = found;
  assign wr_addr_o  = addr_i[sel];
  assign wr_data_o  = data_i[sel];
  assign busy_o     = |pend_q;
  assign fire       = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (grp_load_i) begin
      pend_q <= keep_i;
    end else if (fire) begin
      pend_q[sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) batch_done_o <= 1'b0;
    else         batch_done_o <= fire && exec_i[sel];
  end
endmodule

// File: rtl/regwr_unpacker.sv
module regwr_unpacker
  import regwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00,
  parameter logic [ADDR_W-1:0] EXEC_OFS  = 16'h0100,
  parameter logic [DATA_W/SLOTS-1:0] PAD_IDX = 8'h15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              batch_done_o,
  output logic              err_o
);
  localparam int unsigned IDX_W = DATA_W / SLOTS;

  logic                         busy;
  logic                         grp_load;
  logic [DATA_W-1:0]            idx_word;
  logic [SLOTS-1:0][DATA_W-1:0] val;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [SLOTS-1:0]             slot_pad;
  logic [SLOTS-1:0]             slot_exec;

  regwr_collect #(.DATA_W(DATA_W)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_last_i  (in_last_i),
    .busy_i     (busy),
    .in_ready_o (in_ready_o),
    .grp_load_o (grp_load),
    .idx_word_o (idx_word),
    .val_o      (val),
    .err_o      (err_o)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_map
    regwr_addr_map #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .WIN0_BASE (WIN0_BASE),
      .WIN1_BASE (WIN1_BASE),
      .EXEC_OFS  (EXEC_OFS),
      .PAD_IDX   (PAD_IDX)
    ) u_map (
      .idx_i  (idx_word[k*IDX_W +: IDX_W]),
      .addr_o (slot_addr[k]),
      .pad_o  (slot_pad[k]),
      .exec_o (slot_exec[k])
    );
  end

  regwr_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grp_load_i   (grp_load),
    .keep_i       (~slot_pad),
    .addr_i       (slot_addr),
    .exec_i       (slot_exec),
    .data_i       (val),
    .wr_ready_i   (wr_ready_i),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .busy_o       (busy),
    .batch_done_o (batch_done_o)
  );
endmodule

// File: rtl/regwr_unpacker_chk.sv
module regwr_unpacker_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00,
  parameter logic [ADDR_W-1:0] EXEC_OFS  = 16'h0100,
  parameter logic [ADDR_W-1:0] PAD_ADDR  = 16'h1C54
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              batch_done_o,
  input logic              err_o
);
  localparam int SPAN = 512;
  int a;
  logic in_w0, in_w1, in_exec;
  assign a       = int'(wr_addr_o);
  assign in_w0   = a >= int'(WIN0_BASE) && a < int'(WIN0_BASE) + SPAN;
  assign in_w1   = a >= int'(WIN1_BASE) && a < int'(WIN1_BASE) + SPAN;
  assign in_exec = a >= int'(WIN0_BASE) + int'(EXEC_OFS) && in_w0;

  assert_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (in_w0 || in_w1));

  assert_no_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_addr_o != PAD_ADDR));

  assert_stall_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !in_ready_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_done_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batch_done_o |-> $past(wr_valid_o && wr_ready_i && in_exec));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind regwr_unpacker regwr_unpacker_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WIN0_BASE (WIN0_BASE),
  .WIN1_BASE (WIN1_BASE),
  .EXEC_OFS  (EXEC_OFS),
  .PAD_ADDR  (WIN0_BASE + ADDR_W'({PAD_IDX[DATA_W/4-2:0], 2'b00}))
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready_o   (in_ready_o),
  .wr_valid_o   (wr_valid_o),
  .wr_ready_i   (wr_ready_i),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .batch_done_o (batch_done_o),
  .err_o        (err_o)
);

// File: tb/regwr_unpacker_tb.sv
`timescale 1ns/1ps
module regwr_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        wr_ready = 1'b0;
  logic        in_ready_o, wr_valid_o, batch_done_o, err_o;
  logic [15:0] wr_addr_o;
  logic [31:0] wr_data_o;

  always #2 clk = ~clk;  // 250 MHz

  regwr_unpacker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data), .in_last_i(in_last),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .batch_done_o(batch_done_o), .err_o(err_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  int  m_cnt;
  bit  m_err, m_done;
  logic [31:0] m_idx;
  logic [31:0] m_val [4];
  int  qa[$], qd[$], qe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_err = 0; m_done = 0;
      qa.delete(); qd.delete(); qe.delete();
    end else begin
      bit was_empty;
      was_empty = (qa.size() == 0);
      m_done = 0;
      if (!was_empty && wr_ready) begin
        m_done = (qe[0] != 0);
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qe.pop_front());
      end
      if (was_empty && in_valid) begin
        if (m_cnt == 0) m_idx = in_data; else m_val[m_cnt-1] = in_data;
        if (in_last && m_cnt != 4) begin
          m_err = 1; m_cnt = 0;
        end else if (m_cnt == 4) begin
          for (int k = 0; k < 4; k++) begin
            logic [7:0] ix;
            ix = m_idx[8*k +: 8];
            if (ix != 8'h15) begin
              qa.push_back((ix[7] ? 32'h2C00 : 32'h1C00) + 4 * int'(ix[6:0]));
              qd.push_back(int'(m_val[k]));
              qe.push_back((!ix[7] && ix[6]) ? 1 : 0);
            end
          end
          m_cnt = 0;
        end else m_cnt++;
      end
    end
  end

  // ------------- per-cycle compare, ready driver, port log -------------
  int rdy_mode = 0;
  logic [31:0] rlfsr = 32'h1ACE5EED;
  int la[$], ld[$];
  int hs_cnt = 0, done_cnt = 0;

  always @(negedge clk) begin
    bit nr;
    if (rst_n && !finished) begin
      checks++;
      if (in_ready_o !== (qa.size() == 0)) begin
        errors++; $display("FAIL R6 in_ready act=%0b exp=%0b", in_ready_o, qa.size() == 0);
      end
      if (wr_valid_o !== (qa.size() != 0)) begin
        errors++; $display("FAIL R1 wr_valid act=%0b exp=%0b", wr_valid_o, qa.size() != 0);
      end else if (wr_valid_o) begin
        if (int'(wr_addr_o) != qa[0]) begin
          errors++; $display("FAIL R3 wr_addr act=%h exp=%h", wr_addr_o, qa[0]);
        end
        if (int'(wr_data_o) != qd[0]) begin
          errors++; $display("FAIL R2 wr_data act=%h exp=%h", wr_data_o, qd[0]);
        end
      end
      if (batch_done_o !== m_done) begin
        errors++; $display("FAIL R7 batch_done act=%0b exp=%0b", batch_done_o, m_done);
      end
      if (err_o !== m_err) begin
        errors++; $display("FAIL R8 err act=%0b exp=%0b", err_o, m_err);
      end
      if (batch_done_o) done_cnt++;
    end
    rlfsr = {rlfsr[30:0], rlfsr[31] ^ rlfsr[21] ^ rlfsr[1] ^ rlfsr[0]};
    case (rdy_mode)
      0: nr = 1;
      1: nr = rlfsr[3] | rlfsr[9];
      default: nr = 0;
    endcase
    wr_ready = nr;
    if (rst_n && wr_valid_o && nr) begin
      hs_cnt++; la.push_back(int'(wr_addr_o)); ld.push_back(int'(wr_data_o));
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d, input bit last);
    bit took = 0;
    in_valid = 1; in_data = d; in_last = last;
    while (!took) begin
      took = in_ready_o;
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic send_group(input logic [31:0] iw, input logic [31:0] v0, v1, v2, v3,
                            input bit last);
    send_word(iw, 0); send_word(v0, 0); send_word(v1, 0); send_word(v2, 0);
    send_word(v3, last);
  endtask

  task automatic wait_idle();
    while (wr_valid_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_log();
    la.delete(); ld.delete(); hs_cnt = 0; done_cnt = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] dl = 32'hC0FFEE11;
  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk(in_ready_o === 1'b1, "R9 in_ready in reset", int'(in_ready_o), 1);
    chk(wr_valid_o === 1'b0 && batch_done_o === 1'b0 && err_o === 1'b0,
        "R9 outputs in reset", int'({wr_valid_o, batch_done_o, err_o}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R3 basic window-0 group, last on fifth word
    clear_log();
    send_group(32'h03020100, 32'hA0, 32'hA1, 32'hA2, 32'hA3, 1);
    wait_idle();
    chk(hs_cnt == 4, "R1 write count", hs_cnt, 4);
    chk(la.size() == 4 && la[0] == 'h1C00 && la[3] == 'h1C0C, "R3 window0 addr",
        la.size() > 0 ? la[0] : -1, 'h1C00);
    chk(err_o === 1'b0, "R1 last on fifth word no error", int'(err_o), 0);

    // R2/R4/R5/R7 mixed group: 0x07, pad, 0x40 exec, 0x8A window1
    clear_log();
    send_group(32'h8A401507, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444, 0);
    wait_idle();
    chk(la.size() == 3, "R5 pad slot dropped", la.size(), 3);
    if (la.size() == 3) begin
      chk(la[0] == 'h1C1C && ld[0] == 'h11111111, "R2 slot0 order", la[0], 'h1C1C);
      chk(la[1] == 'h1D00 && ld[1] == 'h33333333, "R2 slot2 data", ld[1], 'h33333333);
      chk(la[2] == 'h2C28 && ld[2] == 'h44444444, "R4 window1 addr", la[2], 'h2C28);
    end
    chk(done_cnt == 1, "R7 one batch pulse", done_cnt, 1);

    // R7 window-1 upper half gives no pulse
    clear_log();
    send_group(32'h151501C0, 32'h5, 32'h6, 32'h7, 32'h8, 0);
    wait_idle();
    chk(la.size() == 2 && la[0] == 'h2D00, "R4 window1 top half",
        la.size() > 0 ? la[0] : -1, 'h2D00);
    chk(done_cnt == 0, "R7 no pulse for window1", done_cnt, 0);

    // R7 boundary indices
    clear_log();
    send_group(32'hFF7F3F80, 32'h1, 32'h2, 32'h3, 32'h4, 0);
    wait_idle();
    chk(la.size() == 4 && la[1] == 'h1CFC && la[2] == 'h1DFC && la[3] == 'h2DFC,
        "R3 boundary addrs", la.size() > 2 ? la[2] : -1, 'h1DFC);
    chk(done_cnt == 1, "R7 pulse at 0x7F only", done_cnt, 1);

    // R5 all-padding group
    clear_log();
    send_group(32'h15151515, 32'h9, 32'h9, 32'h9, 32'h9, 0);
    @(negedge clk);
    chk(hs_cnt == 0, "R5 all pad no writes", hs_cnt, 0);
    chk(in_ready_o === 1'b1, "R5 all pad ready stays high", int'(in_ready_o), 1);

    // R6 full backpressure
    rdy_mode = 2;
    clear_log();
    send_group(32'h04030201, 32'hB1, 32'hB2, 32'hB3, 32'hB4, 0);
    repeat (6) @(negedge clk);
    chk(in_ready_o === 1'b0 && wr_valid_o === 1'b1, "R6 stall holds input",
        int'({in_ready_o, wr_valid_o}), 1);
    chk(wr_addr_o == 16'h1C04, "R6 stalled addr stable", int'(wr_addr_o), 'h1C04);
    rdy_mode = 0;
    wait_idle();
    chk(hs_cnt == 4, "R6 writes after release", hs_cnt, 4);

    // random traffic under random backpressure
    rdy_mode = 1;
    for (int g = 0; g < 40; g++) begin
      logic [31:0] w [5];
      for (int j = 0; j < 5; j++) begin dl = xs(dl); w[j] = dl; end
      if (g % 5 == 0) w[0][15:8] = 8'h15;
      send_group(w[0], w[1], w[2], w[3], w[4], (g % 3) == 0);
    end
    rdy_mode = 0;
    wait_idle();

    // R8 truncated group
    clear_log();
    send_word(32'h03020100, 0); send_word(32'hD0, 0); send_word(32'hD1, 1);
    @(negedge clk);
    chk(err_o === 1'b1, "R8 error raised", int'(err_o), 1);
    chk(hs_cnt == 0, "R8 no partial writes", hs_cnt, 0);
    send_group(32'h0B0A0908, 32'hE0, 32'hE1, 32'hE2, 32'hE3, 0);
    wait_idle();
    chk(la.size() == 4 && la[0] == 'h1C20 && ld[0] == 'hE0, "R8 resync on index",
        la.size() > 0 ? la[0] : -1, 'h1C20);
    chk(err_o === 1'b1, "R8 error sticky", int'(err_o), 1);

    // R9 reset mid-group
    send_word(32'h11111111, 0); send_word(32'h22222222, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(err_o === 1'b0 && in_ready_o === 1'b1 && wr_valid_o === 1'b0, "R9 reset clears",
        int'({err_o, in_ready_o, wr_valid_o}), 2);
    clear_log();
    send_group(32'h07060504, 32'hF0, 32'hF1, 32'hF2, 32'hF3, 0);
    wait_idle();
    chk(la.size() == 4 && la[0] == 'h1C10 && ld[0] == 'hF0, "R9 partial group discarded",
        la.size() > 0 ? la[0] : -1, 'h1C10);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule